// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It divides a fast input clock by N = B·P + A. A small prescaler divides the input by P or by P+1, as a modulus-control signal directs. Two slow counters run once per prescaler cycle. The swallow count A asks for one extra input cycle in each of the first A prescaler cycles. The main count B sets how many prescaler cycles make up one output cycle. The prescaler pair is fixed at build time: either 8/9 or 32/33.

Software-side logic writes A and B with a load strobe into stored registers. The running counters take the stored values only when an output cycle ends, so a period is never cut short. A load that would break the scheme (B smaller than A, or B equal to zero) is refused and flagged. A counter-reset input holds the divider at the start of an output cycle and blocks the output pulse. When it is released, counting restarts cleanly from the stored values.

Top module: `pulse_swallow_div`

## Requirements
- R1: For a stored pair (A, B), successive `div_out` pulses are exactly B·P + A input clock cycles apart.
- R2: The parameter `PS_SEL` picks the prescaler pair: 0 gives P = 8 (divides by 8/9), 1 gives P = 32 (divides by 32/33). Any other value stops elaboration.
- R3: Counting from the cycle in which `div_out` is high, `mod_ctl` is high for exactly A·(P+1) input cycles of each output cycle and low for the rest. `mod_ctl` changes only at a prescaler-cycle boundary.
- R4: With A = 0, `mod_ctl` stays low and the period is B·P. With A = B, every prescaler cycle divides by P+1 and the period is B·(P+1).
- R5: A load with B = 0 or with B < A changes nothing. `load_err` is high for exactly the one cycle after such a load and low after a valid load. The period stays that of the previous stored pair.
- R6: A valid load taken in the middle of an output cycle does not change that cycle: it ends with the old period. The next cycle uses the new pair.
- R7: `div_out` is high for a single input clock cycle per output cycle.
- R8: While `cnt_rst` is high, `div_out` stays low and both counters hold the stored pair. The first pulse comes exactly B·P + A cycles after `cnt_rst` is released.
- R9: After `rst_n`, the stored pair is A = 0, B = 1, so the period is P. `div_out` and `load_err` are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rf | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Synchronous counter hold; blocks output pulses |
| div_a | input | A_W (5) | Swallow count to be stored |
| div_b | input | B_W (13) | Main count to be stored |
| load | input | 1 | Strobe that stores `div_a`/`div_b` |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| mod_ctl | output | 1 | High selects divide by P+1 in the prescaler |
| load_err | output | 1 | One-cycle flag after a refused load |

## Verification
The hardest case to reach is a valid load that arrives while an output cycle is in progress. The cycle must still end with the old period, and only the next period may use the new pair. The stimulus waits for a pulse, raises `load` a few cycles later while it keeps counting, and then measures both the cycle that is running and the one after it. Within each period the bench also counts the cycles in which `mod_ctl` is high, which shows where the swallow phase ends. The edge pairs A = 0 and A = B are run on both prescaler pairs.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;

   // Prescaler pair selector values
   localparam int unsigned PS_PAIR_8_9   = 0;
   localparam int unsigned PS_PAIR_32_33 = 1;

   // Low modulus P for a given selector
   function automatic int unsigned ps_base(input int unsigned sel);
      return (sel == PS_PAIR_32_33) ? 32 : 8;
   endfunction

endpackage

// File: rtl/psd_prescaler.sv
`timescale 1ns/1ps
module psd_prescaler #(
   parameter int unsigned P_BASE = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic swallow,
   output logic tick
);
   localparam int unsigned CW = $clog2(P_BASE + 1);
   localparam logic [CW-1:0] LIM_HI = CW'(P_BASE);
   localparam logic [CW-1:0] LIM_LO = CW'(P_BASE - 1);

   logic [CW-1:0] pc;
   logic [CW-1:0] limit;

   always_comb begin
      limit = swallow ? LIM_HI : LIM_LO;
      tick  = !hold && (pc == limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= '0;
      else if (hold || tick)
         pc <= '0;
      else
         pc <= pc + 1'b1;
   end

   // R3
   pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc <= limit);

endmodule

// File: rtl/psd_shadow.sv
`timescale 1ns/1ps
module psd_shadow #(
   parameter int unsigned A_W   = 5,
   parameter int unsigned B_W   = 13,
   parameter int unsigned RST_A = 0,
   parameter int unsigned RST_B = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   output logic [A_W-1:0] sh_a,
   output logic [B_W-1:0] sh_b,
   output logic           load_err
);
   logic           bad;
   logic [B_W-1:0] a_wide;

   always_comb begin
      a_wide = {{(B_W-A_W){1'b0}}, a_in};
      bad    = (b_in == '0) || (a_wide > b_in);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_a     <= A_W'(RST_A);
         sh_b     <= B_W'(RST_B);
         load_err <= 1'b0;
      end else begin
         load_err <= load && bad;
         if (load && !bad) begin
            sh_a <= a_in;
            sh_b <= b_in;
         end
      end
   end

   // R5
   refused_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> ($stable(sh_a) && $stable(sh_b)));

   // R5
   stored_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_b != '0) && ({{(B_W-A_W){1'b0}}, sh_a} <= sh_b));

endmodule

// File: rtl/psd_swallow.sv
`timescale 1ns/1ps
module psd_swallow #(
   parameter int unsigned A_W   = 5,
   parameter int unsigned B_W   = 13,
   parameter int unsigned RST_A = 0,
   parameter int unsigned RST_B = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic           tick,
   input  logic [A_W-1:0] sh_a,
   input  logic [B_W-1:0] sh_b,
   output logic           mod_ctl,
   output logic           out_pulse
);
   logic [A_W-1:0] a_cnt;
   logic [B_W-1:0] b_cnt;
   logic           last;

   always_comb begin
      mod_ctl = (a_cnt != '0);
      last    = (b_cnt <= B_W'(1));
   end

   // Counters advance once per prescaler cycle (tick is the enable)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt     <= A_W'(RST_A);
         b_cnt     <= B_W'(RST_B);
         out_pulse <= 1'b0;
      end else if (hold) begin
         a_cnt     <= sh_a;
         b_cnt     <= sh_b;
         out_pulse <= 1'b0;
      end else if (tick) begin
         if (last) begin
            a_cnt     <= sh_a;
            b_cnt     <= sh_b;
            out_pulse <= 1'b1;
         end else begin
            a_cnt     <= mod_ctl ? a_cnt - 1'b1 : a_cnt;
            b_cnt     <= b_cnt - 1'b1;
            out_pulse <= 1'b0;
         end
      end else begin
         out_pulse <= 1'b0;
      end
   end

   // R4
   a_within_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {{(B_W-A_W){1'b0}}, a_cnt} <= b_cnt);

   // R7
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_pulse |=> !out_pulse);

   // R8
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !out_pulse);

   // R3
   mod_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !hold) |=> $stable(mod_ctl));

   // R1
   pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_pulse) |-> $past(tick));

endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div #(
   parameter int unsigned PS_SEL = 0,
   parameter int unsigned A_W    = 5,
   parameter int unsigned B_W    = 13,
   parameter int unsigned RST_A  = 0,
   parameter int unsigned RST_B  = 1
) (
   input  logic           clk_rf,
   input  logic           rst_n,
   input  logic           cnt_rst,
   input  logic [A_W-1:0] div_a,
   input  logic [B_W-1:0] div_b,
   input  logic           load,
   output logic           div_out,
   output logic           mod_ctl,
   output logic           load_err
);
   localparam int unsigned P_BASE = psd_pkg::ps_base(PS_SEL);

   // Elaboration-time parameter checks (R2)
   generate
      if (PS_SEL > psd_pkg::PS_PAIR_32_33) begin : g_bad_sel
         $error("PS_SEL must be 0 (8/9) or 1 (32/33)");
      end
      if (A_W < 1 || B_W <= A_W) begin : g_bad_width
         $error("widths need 1 <= A_W < B_W");
      end
      if (RST_B < 1 || RST_A > RST_B || RST_B >= (1 << B_W)) begin : g_bad_rst
         $error("reset pair must satisfy 1 <= RST_B, RST_A <= RST_B");
      end
   endgenerate

   logic           tick;
   logic [A_W-1:0] sh_a;
   logic [B_W-1:0] sh_b;

   psd_shadow #(.A_W(A_W), .B_W(B_W), .RST_A(RST_A), .RST_B(RST_B)) u_shadow (
      .clk(clk_rf), .rst_n(rst_n), .load(load), .a_in(div_a), .b_in(div_b),
      .sh_a(sh_a), .sh_b(sh_b), .load_err(load_err));

   psd_prescaler #(.P_BASE(P_BASE)) u_presc (
      .clk(clk_rf), .rst_n(rst_n), .hold(cnt_rst), .swallow(mod_ctl),
      .tick(tick));

   psd_swallow #(.A_W(A_W), .B_W(B_W), .RST_A(RST_A), .RST_B(RST_B)) u_count (
      .clk(clk_rf), .rst_n(rst_n), .hold(cnt_rst), .tick(tick),
      .sh_a(sh_a), .sh_b(sh_b), .mod_ctl(mod_ctl), .out_pulse(div_out));

   // R9
   reset_quiet_chk: assert property (@(posedge clk_rf)
      !rst_n |=> (!div_out && !load_err));

endmodule

// File: tb/sim_pulse_swallow_div.sv
`timescale 1ns/1ps
module sim_pulse_swallow_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_rst = 1'b0;
   logic [4:0]  a = '0;
   logic [12:0] b = '0;
   logic        load = 1'b0;
   logic        p0, m0, e0, p1, m1, e1;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   pulse_swallow_div #(.PS_SEL(0)) u0 (
      .clk_rf(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .div_a(a), .div_b(b),
      .load(load), .div_out(p0), .mod_ctl(m0), .load_err(e0));

   pulse_swallow_div #(.PS_SEL(1)) u1 (
      .clk_rf(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .div_a(a), .div_b(b),
      .load(load), .div_out(p1), .mod_ctl(m1), .load_err(e1));

   function automatic logic pz(input int s);
      return (s != 0) ? p1 : p0;
   endfunction

   function automatic logic mz(input int s);
      return (s != 0) ? m1 : m0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Wait for a pulse, then count cycles (and mod_ctl-high cycles) to the next
   task automatic meas(input int s, output int n, output int mh);
      int g = 0;
      while (!pz(s) && g < 5000) begin @(negedge clk); g++; end
      n = 0; mh = 0;
      do begin
         if (mz(s)) mh++;
         n++;
         @(negedge clk);
         if (n == 1) chk("R7 pulse low after one cycle", int'(pz(s)), 0);
      end while (!pz(s) && n < 5000);
   endtask

   task automatic do_load(input int av, input int bv, input int exp_err);
      a = 5'(av); b = 13'(bv); load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      chk("R5 load_err p8", int'(e0), exp_err);
      chk("R5 load_err p32", int'(e1), exp_err);
      @(negedge clk);
      chk("R5 load_err one cycle", int'(e0 | e1), 0);
   endtask

   task automatic apply(input int av, input int bv);
      do_load(av, bv, 0);
      cnt_rst = 1'b1;
      @(negedge clk);
      cnt_rst = 1'b0;
   endtask

   task automatic t_reset;
      int n, mh;
      repeat (4) begin
         @(negedge clk);
         chk("R9 quiet in reset", int'(p0 | p1 | e0 | e1), 0);
      end
      rst_n = 1'b1;
      meas(0, n, mh);
      chk("R9 default period p8", n, 8);
      chk("R9 default mod low", mh, 0);
      meas(1, n, mh);
      chk("R9 R2 default period p32", n, 32);
   endtask

   task automatic t_ratio(input int av, input int bv);
      int n, mh;
      apply(av, bv);
      meas(0, n, mh);
      chk("R1 R4 period p8", n, bv * 8 + av);
      chk("R3 mod high p8", mh, av * 9);
      meas(1, n, mh);
      chk("R1 R2 period p32", n, bv * 32 + av);
      chk("R3 mod high p32", mh, av * 33);
   endtask

   task automatic t_defer;
      int n, mh, cnt;
      apply(2, 6);
      meas(0, n, mh);
      cnt = 0;
      do begin
         if (cnt == 3) begin a = 5'd5; b = 13'd11; load = 1'b1; end
         else load = 1'b0;
         cnt++;
         @(negedge clk);
      end while (!p0 && cnt < 5000);
      load = 1'b0;
      chk("R6 running cycle keeps old period", cnt, 6 * 8 + 2);
      meas(0, n, mh);
      chk("R6 next cycle uses new pair", n, 11 * 8 + 5);
   endtask

   task automatic t_invalid;
      int n, mh;
      apply(4, 9);
      do_load(5, 4, 1);
      do_load(0, 0, 1);
      meas(0, n, mh);
      chk("R5 refused load ignored p8", n, 9 * 8 + 4);
      meas(0, n, mh);
      chk("R5 refused load ignored again", n, 9 * 8 + 4);
      meas(1, n, mh);
      chk("R5 refused load ignored p32", n, 9 * 32 + 4);
   endtask

   task automatic t_cntrst;
      int seen = 0;
      int cnt = 0;
      apply(3, 5);
      cnt_rst = 1'b1;
      repeat (200) begin
         @(negedge clk);
         if (p0 || p1) seen++;
      end
      chk("R8 no pulse while held", seen, 0);
      cnt_rst = 1'b0;
      do begin @(negedge clk); cnt++; end while (!p0 && cnt < 5000);
      chk("R8 first pulse after release", cnt, 5 * 8 + 3);
   endtask

   initial begin
      t_reset();
      t_ratio(3, 10);
      t_ratio(0, 5);
      t_ratio(7, 7);
      t_ratio(31, 31);
      t_ratio(1, 40);
      t_ratio(12, 13);
      t_defer();
      t_invalid();
      t_cntrst();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule